// File: doc/BRIEF.md
# Legacy Region Shadow Attribute Decoder

This block decides where each access into the legacy memory area of a PC-style memory map goes. The area runs from 0x80000 to 0xFFFFF. An access can stay in local DRAM, go out to the external bus, or be blocked. A small bank of byte-wide control registers holds the routing choices. System configuration software programs the bank through a simple write and read port. The decoder itself is purely combinational: a 20-bit address and a read/write flag go in, and a 2-bit route code comes out in the same cycle.

Routing can be set per 16 KB half of each 32 KB option-ROM span, and separately for reads and writes. One register is shared between two areas: the 128 KB area below the video window and the top 64 KB of the map. A separate single bit decides whether the video window is forwarded or blocked.

A build-time parameter selects the polarity of the control bits. In the bridge view, a set bit means external. In the memory-controller view, a set bit means local. The same logic therefore serves both chips of a two-part chipset.

Top module: `legacy_shadow_decoder`

## Requirements
- R1: After reset, the configuration reads are: offset 0x58 = 0x02, offset 0x59 = 0x30, and each of offsets 0x5A to 0x5F = 0x33.
- R2: Write masking:
  - A write to offsets 0x59 to 0x5F keeps only the bits in mask 0x33, and the other bits read back as 0.
  - A write to offset 0x58 keeps only bit 1.
  - In offsets 0x59 to 0x5F, bits 0 and 4 are read controls and bits 1 and 5 are write controls.
- R3: A read of any offset outside 0x58 to 0x5F returns 0x00. A write to such an offset changes no register and no route.
- R4: Any address below 0x80000 decodes to local (code 00), whatever the registers hold.
- R5: The span 0x80000 to 0x9FFFF is controlled by offset 0x59: bit 0 for reads and bit 1 for writes.
- R6: The span 0xF0000 to 0xFFFFF is controlled by offset 0x59: bit 4 for reads and bit 5 for writes.
- R7: Offset 0x5A+k (k = 0 to 5) covers 0xC0000 + k*0x8000 for 32 KB.
  - Bits 0 and 1 control the lower 16 KB.
  - Bits 4 and 5 control the upper 16 KB.
- R8: Control-bit polarity:
  - With MC_POLARITY = 0, a set control bit routes that direction external (01) and a clear bit routes it local (00).
  - With MC_POLARITY = 1, the meaning is reversed.
- R9: In the span 0xA0000 to 0xBFFFF, both reads and writes follow bit 1 of offset 0x58: external (01) when it is set, blocked (10) when it is clear. That span is never local.
- R10: Route code and update timing:
  - The route code is 00 local, 01 external, 10 blocked, and it is never 11.
  - The code follows the address and direction combinationally.
  - A register write changes routing only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | Access direction, 1 = write |
| acc_route | output | 2 | Route code: 00 local, 01 external, 10 blocked |

## Verification
The assertions assume the following about the inputs:
- At most one configuration write is presented per clock.
- The configuration and access inputs carry known values at every sampled edge after reset.
- The access address and direction do not change across the edge that captures a write.

The bench satisfies all three by driving every input on the falling edge and holding it for a full cycle. It reads results one nanosecond after a falling edge, or one nanosecond after a rising edge in the timing test. Sweeps put two addresses into every 8 KB step, the start and end of the step, and run both directions on two instances of opposite polarity.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic [1:0] {
    ROUTE_LOCAL = 2'b00,
    ROUTE_EXT   = 2'b01,
    ROUTE_BLOCK = 2'b10
  } route_e;

  // compressed storage of one shadow byte: bits 5,4,1,0
  typedef struct packed {
    logic wr_hi;
    logic rd_hi;
    logic wr_lo;
    logic rd_lo;
  } seg_ctl_t;

  localparam int unsigned NUM_SEG       = 7;       // offsets base+1 .. base+7
  localparam logic [7:0]  BANK_BASE     = 8'h58;
  localparam seg_ctl_t    TOP_RESET     = 4'b1100; // 0x30
  localparam seg_ctl_t    SEG_RESET     = 4'b1111; // 0x33
  localparam logic        VGA_RESET     = 1'b1;    // 0x02
endpackage

// File: rtl/shadow_rst_sync.sv
module shadow_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank
  import shadow_pkg::*;
#(
  parameter int unsigned CFG_AW = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  output logic                         vga_en,
  output seg_ctl_t [NUM_SEG-1:0]       seg_ctl
);
  localparam int unsigned SUB_W = 3;

  logic             in_bank;
  logic [SUB_W-1:0] sub;
  logic             vga_q, vga_d, vga_ce;
  seg_ctl_t [NUM_SEG-1:0] seg_q, seg_d;
  logic     [NUM_SEG-1:0] seg_ce;
  logic             unused_wdata;

  assign in_bank      = (cfg_addr[CFG_AW-1:SUB_W] == BANK_BASE[CFG_AW-1:SUB_W]);
  assign sub          = cfg_addr[SUB_W-1:0];
  assign unused_wdata = ^cfg_wdata;

  // video window enable: next state
  always_comb begin
    vga_ce = cfg_we && in_bank && (sub == '0);
    vga_d  = cfg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vga_q <= VGA_RESET;
    else if (vga_ce) vga_q <= vga_d;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    always_comb begin
      seg_ce[k] = cfg_we && in_bank && (sub == SUB_W'(k + 1));
      seg_d[k]  = '{wr_hi: cfg_wdata[5], rd_hi: cfg_wdata[4],
                    wr_lo: cfg_wdata[1], rd_lo: cfg_wdata[0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seg_q[k] <= (k == 0) ? TOP_RESET : SEG_RESET;
      else if (seg_ce[k]) seg_q[k] <= seg_d[k];
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    if (in_bank) begin
      if (sub == '0) cfg_rdata[1] = vga_q;
      for (int k = 0; k < NUM_SEG; k++) begin
        if (sub == SUB_W'(k + 1)) begin
          cfg_rdata[0] = seg_q[k].rd_lo;
          cfg_rdata[1] = seg_q[k].wr_lo;
          cfg_rdata[4] = seg_q[k].rd_hi;
          cfg_rdata[5] = seg_q[k].wr_hi;
        end
      end
    end
  end

  assign vga_en  = vga_q;
  assign seg_ctl = seg_q;

  // R3: writes outside the bank leave all state untouched
  assert_unimpl_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !in_bank) |=> ($stable(seg_q) && $stable(vga_q)));

  // R2: only masked bits ever read back from the bank
  assert_read_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bank && sub != '0) |-> ((cfg_rdata & ~DATA_W'(8'h33)) == '0));

  // R2: a write to the video byte is captured from bit 1 only
  assert_vga_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_bank && sub == '0) |=> (vga_en == $past(cfg_wdata[1])));
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_pkg::*;
#(
  parameter int unsigned HI_W        = 6,
  parameter bit          MC_POLARITY = 1'b0
) (
  input  logic [HI_W-1:0]         acc_hi,
  input  logic                    acc_write,
  input  logic                    vga_en,
  input  seg_ctl_t [NUM_SEG-1:0]  seg_ctl,
  output logic [1:0]              route
);
  localparam int unsigned TOP = HI_W - 1;

  logic [2:0] span;
  logic       half;
  logic       shadowed;
  logic       ctl;
  seg_ctl_t   pick;
  route_e     route_e_w;

  assign span = acc_hi[TOP-2:TOP-4];
  assign half = acc_hi[TOP-5];

  always_comb begin
    route_e_w = ROUTE_LOCAL;
    shadowed  = 1'b0;
    ctl       = 1'b0;
    pick      = seg_ctl[1];
    if (acc_hi[TOP]) begin
      if (!acc_hi[TOP-1]) begin
        if (!acc_hi[TOP-2]) begin
          shadowed = 1'b1;
          ctl      = acc_write ? seg_ctl[0].wr_lo : seg_ctl[0].rd_lo;
        end else begin
          route_e_w = vga_en ? ROUTE_EXT : ROUTE_BLOCK;
        end
      end else if (acc_hi[TOP-2:TOP-3] == 2'b11) begin
        shadowed = 1'b1;
        ctl      = acc_write ? seg_ctl[0].wr_hi : seg_ctl[0].rd_hi;
      end else begin
        shadowed = 1'b1;
        for (int k = 1; k < NUM_SEG; k++) begin
          if (span == 3'(k - 1)) pick = seg_ctl[k];
        end
        if (half) ctl = acc_write ? pick.wr_hi : pick.rd_hi;
        else      ctl = acc_write ? pick.wr_lo : pick.rd_lo;
      end
    end
    if (shadowed) route_e_w = (ctl ^ MC_POLARITY) ? ROUTE_EXT : ROUTE_LOCAL;
  end

  assign route = route_e_w;
endmodule

// File: rtl/legacy_shadow_decoder.sv
module legacy_shadow_decoder
  import shadow_pkg::*;
#(
  parameter int unsigned CFG_AW      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 20,
  parameter bit          MC_POLARITY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic [1:0]        acc_route
);
  localparam int unsigned HI_W  = 6;
  localparam int unsigned LOW_W = ADDR_W - HI_W;

  logic                   rst_sync_n;
  logic                   vga_en;
  seg_ctl_t [NUM_SEG-1:0] seg_ctl;
  logic                   unused_low;

  assign unused_low = ^acc_addr[LOW_W-1:0];

  shadow_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  shadow_regbank #(.CFG_AW(CFG_AW), .DATA_W(DATA_W)) u_regbank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .vga_en    (vga_en),
    .seg_ctl   (seg_ctl)
  );

  shadow_decode #(.HI_W(HI_W), .MC_POLARITY(MC_POLARITY)) u_decode (
    .acc_hi    (acc_addr[ADDR_W-1:LOW_W]),
    .acc_write (acc_write),
    .vga_en    (vga_en),
    .seg_ctl   (seg_ctl),
    .route     (acc_route)
  );

  // R10: illegal route code never produced
  assert_route_legal_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_route != 2'b11);

  // R4: low memory always local
  assert_low_local_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_addr[ADDR_W-1] |-> acc_route == ROUTE_LOCAL);

  // R9: video window never local
  assert_vga_not_local_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_addr[ADDR_W-1 -: 3] == 3'b101) |-> acc_route != ROUTE_LOCAL);

  // R9/R10: video byte write governs the window from the next cycle
  assert_vga_follow_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr == CFG_AW'(8'h58)) |=>
      ((acc_addr[ADDR_W-1 -: 3] != 3'b101) ||
       (acc_route == ($past(cfg_wdata[1]) ? ROUTE_EXT : ROUTE_BLOCK))));

  // R7/R8: first option byte governs the first 16 KB reads from the next cycle
  assert_seg_follow_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr == CFG_AW'(8'h5A)) |=>
      ((acc_addr[ADDR_W-1 -: 6] != 6'b110000) || acc_write ||
       (acc_route == (($past(cfg_wdata[0]) ^ MC_POLARITY) ? ROUTE_EXT : ROUTE_LOCAL))));
endmodule

// File: tb/legacy_shadow_decoder_bench.sv
`timescale 1ns/1ps
module legacy_shadow_decoder_bench;
  localparam real CLK_P = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  rdata_br, rdata_mc;
  logic [19:0] acc_addr = 20'h0;
  logic        acc_write = 1'b0;
  logic [1:0]  route_br, route_mc;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_reg [8];

  always #(CLK_P/2) clk = ~clk;

  legacy_shadow_decoder #(.MC_POLARITY(1'b0)) u_legacy_shadow_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_br), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_route(route_br));

  legacy_shadow_decoder #(.MC_POLARITY(1'b1)) u_legacy_shadow_decoder_mc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_mc), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_route(route_mc));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [19:0] a, input logic wr, input logic pol);
    logic b;
    logic [7:0] r;
    int k;
    if (a < 20'h80000) return 2'b00;
    if (a < 20'hA0000) b = wr ? m_reg[1][1] : m_reg[1][0];
    else if (a < 20'hC0000) return m_reg[0][1] ? 2'b01 : 2'b10;
    else if (a >= 20'hF0000) b = wr ? m_reg[1][5] : m_reg[1][4];
    else begin
      k = int'((a - 20'hC0000) / 20'h8000);
      r = m_reg[2 + k];
      if (((a - 20'hC0000) % 20'h8000) >= 20'h4000) b = wr ? r[5] : r[4];
      else b = wr ? r[1] : r[0];
    end
    return (b ^ pol) ? 2'b01 : 2'b00;
  endfunction

  function automatic string region_tag(input logic [19:0] a);
    if (a < 20'h80000) return "R4";
    if (a < 20'hA0000) return "R5";
    if (a < 20'hC0000) return "R9";
    if (a >= 20'hF0000) return "R6";
    return "R7";
  endfunction

  task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ofs >= 8'h58 && ofs <= 8'h5F)
      m_reg[ofs - 8'h58] = d & ((ofs == 8'h58) ? 8'h02 : 8'h33);
  endtask

  task automatic cfg_check(input logic [7:0] ofs, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = ofs;
    #1;
    chk($sformatf("%s rd br ofs=%h", tag, ofs), rdata_br, exp);
    chk($sformatf("%s rd mc ofs=%h", tag, ofs), rdata_mc, exp);
  endtask

  task automatic route_check(input logic [19:0] a, input logic wr, input string tag);
    @(negedge clk);
    acc_addr = a; acc_write = wr;
    #1;
    chk($sformatf("%s route br a=%h wr=%0d", tag, a, wr), {6'b0, route_br}, {6'b0, model(a, wr, 1'b0)});
    chk($sformatf("%s R8 route mc a=%h wr=%0d", tag, a, wr), {6'b0, route_mc}, {6'b0, model(a, wr, 1'b1)});
  endtask

  task automatic t_reset();
    m_reg[0] = 8'h02; m_reg[1] = 8'h30;
    for (int i = 2; i < 8; i++) m_reg[i] = 8'h33;
    for (int i = 0; i < 8; i++) cfg_check(8'h58 + 8'(i), m_reg[i], "R1");
    route_check(20'hA0000, 1'b0, "R1 R9");
    route_check(20'hC0000, 1'b1, "R1 R7");
    route_check(20'h80000, 1'b0, "R1 R5");
  endtask

  task automatic t_mask();
    cfg_write(8'h5C, 8'hFF);
    cfg_check(8'h5C, 8'h33, "R2");
    cfg_write(8'h58, 8'hFD);
    cfg_check(8'h58, 8'h00, "R2");
    cfg_write(8'h58, 8'hFF);
    cfg_check(8'h58, 8'h02, "R2");
    cfg_write(8'h59, 8'hCC);
    cfg_check(8'h59, 8'h00, "R2");
  endtask

  task automatic t_unimpl();
    cfg_write(8'h60, 8'hFF);
    cfg_write(8'h57, 8'h00);
    cfg_write(8'h50, 8'h00);
    cfg_check(8'h60, 8'h00, "R3");
    cfg_check(8'h57, 8'h00, "R3");
    cfg_check(8'h5C, 8'h33, "R3");
    cfg_check(8'h58, 8'h02, "R3");
    route_check(20'hD0000, 1'b0, "R3");
    route_check(20'hB0000, 1'b1, "R3");
  endtask

  task automatic t_low();
    for (int i = 0; i < 7; i++) cfg_write(8'h59 + 8'(i), 8'h33);
    route_check(20'h00000, 1'b0, "R4");
    route_check(20'h7FFFF, 1'b1, "R4");
    for (int i = 0; i < 7; i++) cfg_write(8'h59 + 8'(i), 8'h00);
    route_check(20'h40000, 1'b0, "R4");
    route_check(20'h7FFFF, 1'b0, "R4");
  endtask

  task automatic t_sweep(input logic [7:0] p58, input logic [7:0] p59, input logic [47:0] pseg);
    cfg_write(8'h58, p58);
    cfg_write(8'h59, p59);
    for (int i = 0; i < 6; i++) cfg_write(8'h5A + 8'(i), pseg[8*i +: 8]);
    for (int s = 0; s < 72; s++) begin
      for (int o = 0; o < 2; o++) begin
        for (int w = 0; w < 2; w++) begin
          logic [19:0] a;
          a = 20'h70000 + 20'(s) * 20'h2000 + (o != 0 ? 20'h1FFF : 20'h0);
          route_check(a, w[0], region_tag(a));
        end
      end
    end
  endtask

  task automatic t_vga();
    cfg_write(8'h58, 8'h00);
    route_check(20'hA0000, 1'b0, "R9");
    route_check(20'hBFFFF, 1'b1, "R9");
    cfg_write(8'h58, 8'h02);
    route_check(20'hA8000, 1'b0, "R9");
    route_check(20'hBFFFF, 1'b1, "R9");
  endtask

  task automatic t_timing();
    cfg_write(8'h59, 8'h00);
    @(negedge clk);
    acc_addr = 20'h80000; acc_write = 1'b0;
    cfg_we = 1'b1; cfg_addr = 8'h59; cfg_wdata = 8'h01;
    #1;
    chk("R10 before edge br", {6'b0, route_br}, 8'h00);
    chk("R10 before edge mc", {6'b0, route_mc}, 8'h01);
    @(posedge clk);
    #1;
    chk("R10 after edge br", {6'b0, route_br}, 8'h01);
    chk("R10 after edge mc", {6'b0, route_mc}, 8'h00);
    acc_write = 1'b1;
    #1;
    chk("R10 comb dir br", {6'b0, route_br}, 8'h00);
    @(negedge clk);
    cfg_we = 1'b0;
    m_reg[1] = 8'h01;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mask();
    t_unimpl();
    t_low();
    t_sweep(8'h00, 8'h21, {8'h31, 8'h12, 8'h20, 8'h10, 8'h02, 8'h01});
    t_sweep(8'h02, 8'h12, {8'h33, 8'h00, 8'h22, 8'h11, 8'h03, 8'h30});
    t_vga();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule